// File: doc/BRIEF.md
# Smart Card Character Receiver with Parity Error Signalling

This block receives asynchronous characters from a smart card on one shared, open-drain data line. The bit period is a fixed 372 cycles of the card clock. Each character holds a low start bit, eight data bits sent least significant bit first (high means 1) and an even-parity bit. The receiver finds the start bit on a falling edge and samples every bit once, at its midpoint.

When a character arrives with correct parity, the receiver latches the data byte and sets a receive-full flag. A read strobe clears that flag. When the parity is wrong, the receiver leaves the stored byte and the receive-full flag alone and sets a parity-error flag. During the guard period it also pulls the line low, which tells the card to send the character again. Software clears the parity-error flag with a strobe, and it must do so before the parity bit of the next character is sampled.

A receive-interrupt enable gates two level interrupt requests, one for received data and one for errors. The line drive enable output goes to an open-drain pad that pulls the line low while the enable is high.

Top module: `sc_char_rx`

## Requirements
- R1: After a synchronous active-low reset, rx_full, parity_err, line_drive_en, rxi_req and eri_req are all 0.
- R2: A frame is a low start bit, then 8 data bits least significant first with high meaning 1, then an even-parity bit (the count of ones over data and parity is even), each 372 clock cycles long. For a frame with correct parity, rx_data takes the byte and rx_full goes to 1 on the 3537th rising edge after line_in first goes low (2 synchronizer edges, 1 edge to detect, 9 full bits and a half bit). It is still at its old value after the 3536th edge.
- R3: For a frame with wrong parity, parity_err goes to 1 on that same 3537th edge.
- R4: A frame with wrong parity changes neither rx_full nor rx_data.
- R5: A one-cycle pulse on rd_strobe clears rx_full at the next rising edge. A character completing on that same edge takes priority and sets the flag.
- R6: For a frame with correct parity, line_drive_en stays 0 through the guard period after the parity bit.
- R7: After a wrong-parity sample, line_drive_en goes high on the edge 186 cycles later (the end of the parity bit). It stays high for 558 cycles (1.5 bit periods) and then falls, which releases the line.
- R8: A falling edge on line_in is taken as a start bit only if the line is still low at the half-bit sample. A line that is high there is ignored, sets no flag and causes no drive, and a later frame is received normally.
- R9: A pulse on per_clr clears parity_err at the next edge. A correctly received character does not clear parity_err.
- R10: rxi_req equals rx_full AND rx_int_en, and eri_req equals parity_err AND rx_int_en, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Level of the shared data line |
| line_drive_en | output | 1 | 1 = pull the data line low for the error signal |
| rx_int_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Read / DMA strobe, clears rx_full |
| per_clr | input | 1 | Strobe that clears parity_err |
| rx_data | output | 8 | Last correctly received byte |
| rx_full | output | 1 | A received byte is waiting |
| parity_err | output | 1 | A character failed its parity check |
| rxi_req | output | 1 | Receive-data interrupt request |
| eri_req | output | 1 | Receive-error interrupt request |

## Verification
The flag results of a frame are due on the 3537th rising edge after the start bit is applied. The error drive begins 186 edges after that and lasts 558 cycles. Strobe effects and the interrupt outputs follow one edge later or at once. The bench drives every input at a falling edge and counts rising edges from that point. It checks the old value at the falling edge just before each due edge and the new value at the falling edge just after it. For a correct frame, and for a rejected start glitch, it watches the drive enable on every cycle across the window where an error signal could appear.

// File: rtl/sc_rx_pkg.sv
// Package: shared types for the smart card character receiver.
// Assumes: nothing beyond the IEEE 1800-2017 base types.
package sc_rx_pkg;

    // Receiver sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_ERR
    } rx_state_t;

endpackage

// File: rtl/sc_line_sync.sv
// Module: sc_line_sync
// Brings the asynchronous data line into the clock domain through a
// flop chain and flags a high-to-low transition of the synchronized line.
// Assumes: STAGES >= 2; the line idles high, so the chain resets to ones.
module sc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw line through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], line_in};
    end

    // Hold the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign line_s = chain_q[STAGES-1];
    assign fall   = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/sc_frame_ctrl.sv
// Module: sc_frame_ctrl
// Sequences one character: start confirmation, LSB-first data capture,
// even-parity check and, on a parity failure, the low error pulse on the
// line. Gives single-cycle strobes for a good or a bad character.
// Assumes: line_s is synchronized; ETU is even; ETU <= ERR_LEN <= 2*ETU.
module sc_frame_ctrl
    import sc_rx_pkg::*;
#(
    parameter int ETU     = 372,
    parameter int ERR_LEN = 558,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_s,
    input  logic              fall,
    output logic [DATA_W-1:0] shift_data,
    output logic              good_stb,
    output logic              err_stb,
    output logic              drive_en
);

    localparam int MAXC = (ERR_LEN > ETU) ? ERR_LEN : ETU;
    localparam int CW   = $clog2(MAXC);
    localparam int BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] MID_C  = CW'(ETU / 2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(ETU - 1);
    localparam logic [CW-1:0] ERR_C  = CW'(ERR_LEN - 1);
    localparam logic [BW-1:0] TOP_B  = BW'(DATA_W - 1);

    rx_state_t         state_q;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bidx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              bad_q;
    logic              mid;
    logic              last;
    logic              par_bad;

    assign mid     = (cnt_q == MID_C);
    assign last    = (cnt_q == LAST_C);
    assign par_bad = (^shreg_q) ^ line_s;

    // Walk through the bit slots of a character and the error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bidx_q  <= '0;
            shreg_q <= '0;
            bad_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (fall) state_q <= ST_START;
                end
                ST_START: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (mid && line_s) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else if (last) begin
                        state_q <= ST_DATA;
                        cnt_q   <= '0;
                        bidx_q  <= '0;
                    end
                end
                ST_DATA: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (mid) shreg_q <= {line_s, shreg_q[DATA_W-1:1]};
                    if (last) begin
                        cnt_q <= '0;
                        if (bidx_q == TOP_B) state_q <= ST_PAR;
                        else                 bidx_q  <= bidx_q + 1'b1;
                    end
                end
                ST_PAR: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (mid) bad_q <= par_bad;
                    if (last) begin
                        cnt_q   <= '0;
                        state_q <= bad_q ? ST_ERR : ST_IDLE;
                    end
                end
                ST_ERR: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == ERR_C) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign shift_data = shreg_q;
    assign good_stb   = (state_q == ST_PAR) && mid && !par_bad;
    assign err_stb    = (state_q == ST_PAR) && mid && par_bad;
    assign drive_en   = (state_q == ST_ERR);

    // R8: a start edge that reads high at the half-bit point is dropped
    p_glitch_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && mid && line_s) |=> (state_q == ST_IDLE && !drive_en));

    // R6: a correct character ends without any drive of the line
    p_quiet_good_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAR && last && !bad_q) |=> !drive_en);

    // R7: the error pulse ends only after its full length
    p_drive_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_en) |-> ($past(cnt_q) == ERR_C));

endmodule

// File: rtl/sc_rx_flags.sv
// Module: sc_rx_flags
// Holds the received byte and the receive-full and parity-error flags,
// and forms the gated interrupt requests.
// Assumes: good_stb and err_stb are single-cycle and never both high.
module sc_rx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              good_stb,
    input  logic              err_stb,
    input  logic [DATA_W-1:0] data_in,
    input  logic              rd_strobe,
    input  logic              per_clr,
    input  logic              rx_int_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              parity_err,
    output logic              rxi_req,
    output logic              eri_req
);

    // Latch the byte of a correct character
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_data <= '0;
        else if (good_stb) rx_data <= data_in;
    end

    // Receive-full: set by a good character, cleared by a read
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_full <= 1'b0;
        else if (good_stb)  rx_full <= 1'b1;
        else if (rd_strobe) rx_full <= 1'b0;
    end

    // Parity error: set by a bad character, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)       parity_err <= 1'b0;
        else if (err_stb) parity_err <= 1'b1;
        else if (per_clr) parity_err <= 1'b0;
    end

    assign rxi_req = rx_full & rx_int_en;
    assign eri_req = parity_err & rx_int_en;

    // R3: a parity failure always leaves the error flag set
    p_per_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_stb |=> parity_err);

    // R4: a parity failure leaves the stored byte untouched
    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_stb |=> $stable(rx_data));

    // R4: a parity failure does not move the receive-full flag
    p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stb && !rd_strobe) |=> $stable(rx_full));

    // R5: a read with no new character drops the receive request
    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !good_stb) |=> !rxi_req);

endmodule

// File: rtl/sc_char_rx.sv
// Module: sc_char_rx
// Smart card character receiver: synchronizes the shared line, frames
// and parity-checks each character, signals a parity failure back onto
// the line, and presents the data, the flags and the interrupt requests.
// Assumes: an external open-drain pad pulls the line low while
// line_drive_en is high; the card clock drives clk.
module sc_char_rx #(
    parameter int ETU      = 372,
    parameter int ERR_LEN  = 558,
    parameter int DATA_W   = 8,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output logic              line_drive_en,
    input  logic              rx_int_en,
    input  logic              rd_strobe,
    input  logic              per_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              parity_err,
    output logic              rxi_req,
    output logic              eri_req
);

    logic              line_s;
    logic              fall;
    logic [DATA_W-1:0] shift_data;
    logic              good_stb;
    logic              err_stb;

    sc_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .line_s (line_s),
        .fall   (fall)
    );

    sc_frame_ctrl #(.ETU(ETU), .ERR_LEN(ERR_LEN), .DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (line_s),
        .fall      (fall),
        .shift_data(shift_data),
        .good_stb  (good_stb),
        .err_stb   (err_stb),
        .drive_en  (line_drive_en)
    );

    sc_rx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .good_stb  (good_stb),
        .err_stb   (err_stb),
        .data_in   (shift_data),
        .rd_strobe (rd_strobe),
        .per_clr   (per_clr),
        .rx_int_en (rx_int_en),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .parity_err(parity_err),
        .rxi_req   (rxi_req),
        .eri_req   (eri_req)
    );

    // R1: nothing is flagged or driven in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!rx_full && !parity_err && !line_drive_en));

    // R3/R4: one sample never both accepts and rejects a character
    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(good_stb && err_stb));

endmodule

// File: tb/sc_char_rx_bench.sv
// Directed bench for sc_char_rx: one task for each scenario, each task
// checking its own results at counted clock edges.
module sc_char_rx_bench;

    localparam int ETU     = 372;
    localparam int ERR_LEN = 558;
    localparam int DUE     = 3537;   // edge at which the flags update

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card = 1'b1;
    logic       line_in;
    logic       line_drive_en;
    logic       rx_int_en = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       per_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       parity_err;
    logic       rxi_req;
    logic       eri_req;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  m_full  = 1'b0;
    bit  m_per   = 1'b0;
    logic [7:0] m_data = 8'h00;

    always #5 clk = ~clk;

    // Open-drain line: the card and the receiver both pull low
    assign line_in = card & ~line_drive_en;

    sc_char_rx u_sc_char_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_in      (line_in),
        .line_drive_en(line_drive_en),
        .rx_int_en    (rx_int_en),
        .rd_strobe    (rd_strobe),
        .per_clr      (per_clr),
        .rx_data      (rx_data),
        .rx_full      (rx_full),
        .parity_err   (parity_err),
        .rxi_req      (rxi_req),
        .eri_req      (eri_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_irq(input string req);
        chk(rxi_req == (m_full & rx_int_en), req, rxi_req, int'(m_full & rx_int_en));
        chk(eri_req == (m_per & rx_int_en), req, eri_req, int'(m_per & rx_int_en));
    endtask

    // Send one frame; check flag timing, data and the error drive window
    task automatic send_frame(input logic [7:0] d, input bit bad_par);
        logic [9:0] bits;
        bit good;
        good = !bad_par;
        bits = {(^d) ^ bad_par, d, 1'b0};
        @(negedge clk);
        card = bits[0];
        fork
            begin
                for (int i = 1; i < 10; i++) begin
                    repeat (ETU) @(negedge clk);
                    card = bits[i];
                end
                repeat (ETU) @(negedge clk);
                card = 1'b1;
            end
            begin
                repeat (DUE - 1) @(posedge clk);
                @(negedge clk);
                if (good) chk(rx_full == m_full, "R2", rx_full, m_full);
                else      chk(parity_err == m_per, "R3", parity_err, m_per);
                @(posedge clk);
                @(negedge clk);
                if (good) begin
                    m_full = 1'b1;
                    m_data = d;
                    chk(rx_full == 1'b1, "R2", rx_full, 1);
                    chk(rx_data == d, "R2", rx_data, d);
                end else begin
                    m_per = 1'b1;
                    chk(parity_err == 1'b1, "R3", parity_err, 1);
                    chk(rx_full == m_full, "R4", rx_full, m_full);
                    chk(rx_data == m_data, "R4", rx_data, m_data);
                end
                check_irq("R10");
                if (good) begin
                    bit seen;
                    seen = 1'b0;
                    for (int k = 0; k < ERR_LEN + 300; k++) begin
                        @(negedge clk);
                        if (line_drive_en) seen = 1'b1;
                    end
                    chk(!seen, "R6", seen, 0);
                end else begin
                    repeat (ETU / 2 - 1) @(posedge clk);
                    @(negedge clk);
                    chk(line_drive_en == 1'b0, "R7", line_drive_en, 0);
                    @(posedge clk);
                    @(negedge clk);
                    chk(line_drive_en == 1'b1, "R7", line_drive_en, 1);
                    repeat (ERR_LEN - 1) @(posedge clk);
                    @(negedge clk);
                    chk(line_drive_en == 1'b1, "R7", line_drive_en, 1);
                    @(posedge clk);
                    @(negedge clk);
                    chk(line_drive_en == 1'b0, "R7", line_drive_en, 0);
                    repeat (ETU) @(negedge clk);
                end
            end
        join
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_full == 1'b0, "R1", rx_full, 0);
        chk(parity_err == 1'b0, "R1", parity_err, 0);
        chk(line_drive_en == 1'b0, "R1", line_drive_en, 0);
        chk(rxi_req == 1'b0, "R1", rxi_req, 0);
        chk(eri_req == 1'b0, "R1", eri_req, 0);
    endtask

    task automatic t_read;
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        m_full = 1'b0;
        chk(rx_full == 1'b0, "R5", rx_full, 0);
        check_irq("R5");
    endtask

    task automatic t_per_clear;
        @(negedge clk);
        per_clr = 1'b1;
        @(negedge clk);
        per_clr = 1'b0;
        m_per = 1'b0;
        chk(parity_err == 1'b0, "R9", parity_err, 0);
        check_irq("R9");
    endtask

    task automatic t_glitch;
        bit seen;
        seen = 1'b0;
        @(negedge clk);
        card = 1'b0;
        repeat (40) @(negedge clk);
        card = 1'b1;
        for (int k = 0; k < 4500; k++) begin
            @(negedge clk);
            if (line_drive_en) seen = 1'b1;
        end
        chk(!seen, "R8", seen, 0);
        chk(rx_full == m_full, "R8", rx_full, m_full);
        chk(parity_err == m_per, "R8", parity_err, m_per);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin : main
        t_reset();
        rx_int_en = 1'b1;
        send_frame(8'hA5, 1'b0);          // R2 R6 R10
        t_read();                          // R5
        send_frame(8'h3C, 1'b1);          // R3 R4 R7
        send_frame(8'h01, 1'b0);          // R9: good byte keeps the error flag
        chk(parity_err == 1'b1, "R9", parity_err, 1);
        t_per_clear();                     // R9
        rx_int_en = 1'b0;
        @(negedge clk);
        check_irq("R10");
        send_frame(8'hFF, 1'b1);          // R10 gating with enable off
        rx_int_en = 1'b1;
        t_read();
        t_per_clear();
        t_glitch();                        // R8
        send_frame(8'h80, 1'b0);          // R8 resync after the glitch
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule